// File: doc/BRIEF.md
# Transmit Descriptor Builder

This block converts the buffer fragments of one outgoing packet into 128-bit transmit descriptors. Each descriptor consists of two 64-bit words. A packet begins with a start command that carries the total packet length, an urgency flag and optional header-copy controls (an enable and a header entry index). The caller then presents fragments, each with an address, a length and a mapping type, one per valid/ready handshake. Every accepted fragment becomes one descriptor.

The builder subtracts each fragment length from the length still owed. When that count reaches zero, the packet closes. If the total length is not a whole number of 4-byte dwords, one extra pad descriptor is appended. It points at a fixed pad buffer and covers the 1 to 3 missing bytes. The closing descriptor gets the last flag, and for an urgent packet it also gets the interrupt and head-writeback flags.

Descriptors leave through a one-entry valid/ready output stage. A fragment that cannot legally be placed is dropped and raises a sticky error flag.

Top module: `sdesc_builder`

## Requirements
- R1: After reset, desc_valid, frag_ready, start_rej and frag_err are 0, and start_ready is 1.
- R2: A start command is accepted when start_valid=1 and start_ready=1. If its length is 0 or above 16383, start_rej pulses high in the cycle after acceptance, no descriptor is produced, and start_ready stays 1.
- R3: Word 0 holds the first flag at bit 63, the last flag at bit 62, the byte count at bits 61:48 and the buffer address at bits 47:0.
- R4: Word 1 holds the fragment's mapping type at bits 3:2, the interrupt flag at bit 1 and the head-writeback flag at bit 0. Bits 63:32 (header-update word), bits 31:16 and bits 7:4 (header dword count) are zero.
- R5: Only the first descriptor emitted for a packet carries the first flag. When header copy is requested, that descriptor alone carries header mode 1 at bits 15:13 and the header index at bits 12:8. All other descriptors carry 0 in bits 15:8.
- R6: Each accepted fragment reduces the remaining length by its own length. The fragment that brings it to zero closes the packet. For a length that is a multiple of 4, that fragment's descriptor carries the last flag.
- R7: If the packet length modulo 4 is nonzero, a pad descriptor follows the closing fragment. The pad descriptor has address pad_addr, byte count 4 minus (length mod 4), mapping type 0 and the last flag. The closing fragment's descriptor then lacks the last flag.
- R8: For an urgent packet, the last descriptor carries bits 1 and 0 of word 1. Every other descriptor, and every descriptor of a non-urgent packet, has both bits clear.
- R9: A fragment longer than the remaining length is accepted and dropped. It produces no descriptor, leaves the remaining length unchanged and sets frag_err, which stays 1 until reset.
- R10: A packet emits at most MAX_DESC (64) descriptors, counting the pad. A fragment that would need more slots is dropped and sets frag_err. A fragment needs two slots when it closes an unaligned packet, and one slot otherwise.
- R11: While desc_valid=1 and desc_ready=0, desc_valid stays 1 and desc_w0/desc_w1 stay unchanged in the next cycle.
- R12: start_ready is 1 only while no packet is open and no pad is pending. frag_ready is 0 whenever start_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Packet start command valid |
| start_ready | output | 1 | Builder idle, able to take a start command |
| start_len | input | LEN_W | Total packet length in bytes |
| start_urgent | input | 1 | Request interrupt and head writeback on the last descriptor |
| start_hcopy | input | 1 | Request header copy on the first descriptor |
| start_hidx | input | 5 | Header entry index used with header copy |
| start_rej | output | 1 | One-cycle pulse: start command rejected for its length |
| frag_valid | input | 1 | Fragment valid |
| frag_ready | output | 1 | Fragment accepted this cycle when valid |
| frag_addr | input | 48 | Fragment buffer address |
| frag_len | input | 14 | Fragment length in bytes |
| frag_mtype | input | 2 | Fragment mapping type |
| pad_addr | input | 48 | Address of the pad buffer |
| desc_valid | output | 1 | Descriptor output valid |
| desc_ready | input | 1 | Descriptor consumer ready |
| desc_w0 | output | 64 | Descriptor word 0 |
| desc_w1 | output | 64 | Descriptor word 1 |
| frag_err | output | 1 | Sticky fragment error flag |

## Verification
Two functions can meet in the same cycle. One is the close of a packet by its final fragment, which also schedules the pad descriptor. The other is backpressure on the output stage, which must hold the closing descriptor while the pad waits for a free slot. The bench drives desc_ready at random and also provides unaligned packets whose last fragment lands while the output is stalled. It then requires the closing descriptor to stay frozen and the pad to follow it exactly once, carrying the last and urgency bits, in the order a bench model predicts. A second collision is a descriptor-limit drop together with a closing fragment. This is provoked by a 66-byte packet whose unaligned closing fragment arrives with 63 slots already used, and is judged by the absence of any new descriptor and a raised error flag.

// File: rtl/sdesc_pkg.sv
package sdesc_pkg;

    localparam int ADDR_W      = 48;
    localparam int BC_W        = 14;
    localparam int HIDX_W      = 5;
    localparam int MT_W        = 2;
    localparam int MAX_PKT_LEN = 16383;

    localparam logic [2:0] HMODE_NONE = 3'd0;
    localparam logic [2:0] HMODE_COPY = 3'd1;

    // word 0: bit 63 first, bit 62 last, 61:48 byte count, 47:0 address
    typedef struct packed {
        logic              first;
        logic              last;
        logic [BC_W-1:0]   bcount;
        logic [ADDR_W-1:0] addr;
    } dw0_t;

    // word 1: from bit 63 down to bit 0
    typedef struct packed {
        logic [31:0]       hupd;
        logic [15:0]       rsvd;
        logic [2:0]        hmode;
        logic [HIDX_W-1:0] hidx;
        logic [3:0]        hdws;
        logic [MT_W-1:0]   mtype;
        logic              irq;
        logic              hwb;
    } dw1_t;

    typedef struct packed {
        dw0_t w0;
        dw1_t w1;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FRAG = 2'd1,
        ST_PAD  = 2'd2
    } bld_state_e;

    // bytes needed to round a length with the given low bits up to a dword
    function automatic logic [BC_W-1:0] pad_count(input logic [1:0] tail);
        logic [2:0] four_minus;
        four_minus = 3'd4 - {1'b0, tail};
        return BC_W'(four_minus);
    endfunction

    function automatic desc_t make_desc(
        input logic              first,
        input logic              last,
        input logic [BC_W-1:0]   bcount,
        input logic [ADDR_W-1:0] addr,
        input logic              hcopy,
        input logic [HIDX_W-1:0] hidx,
        input logic [MT_W-1:0]   mtype,
        input logic              urgent
    );
        desc_t d;
        d            = '0;
        d.w0.first   = first;
        d.w0.last    = last;
        d.w0.bcount  = bcount;
        d.w0.addr    = addr;
        d.w1.hmode   = (first && hcopy) ? HMODE_COPY : HMODE_NONE;
        d.w1.hidx    = (first && hcopy) ? hidx : '0;
        d.w1.mtype   = mtype;
        d.w1.irq     = last && urgent;
        d.w1.hwb     = last && urgent;
        return d;
    endfunction

endpackage

// File: rtl/sdesc_len_track.sv
module sdesc_len_track
    import sdesc_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int MAX_DESC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             take,
    input  logic [BC_W-1:0]  frag_len,
    input  logic             pad_take,
    output logic             fits,
    output logic             closes,
    output logic             need_pad,
    output logic [1:0]       tail_bytes
);
    localparam int CNT_W = $clog2(MAX_DESC + 1);
    localparam int SUM_W = CNT_W + 1;

    logic [LEN_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       tail_q;
    logic [LEN_W-1:0] flen;
    logic [SUM_W-1:0] slots_after;

    assign flen        = LEN_W'(frag_len);
    assign closes      = (flen == rem_q);
    assign need_pad    = closes && (tail_q != 2'd0);
    assign slots_after = SUM_W'(cnt_q) + (need_pad ? SUM_W'(2) : SUM_W'(1));
    assign fits        = (flen <= rem_q) && (slots_after <= SUM_W'(MAX_DESC));
    assign tail_bytes  = tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            cnt_q  <= '0;
            tail_q <= 2'd0;
        end else if (load) begin
            rem_q  <= load_len;
            cnt_q  <= '0;
            tail_q <= load_len[1:0];
        end else if (take) begin
            rem_q  <= rem_q - flen;
            cnt_q  <= cnt_q + CNT_W'(1);
        end else if (pad_take) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sdesc_assemble.sv
module sdesc_assemble
    import sdesc_pkg::*;
(
    input  logic              use_pad,
    input  logic              first,
    input  logic              last,
    input  logic [ADDR_W-1:0] frag_addr,
    input  logic [BC_W-1:0]   frag_len,
    input  logic [MT_W-1:0]   frag_mtype,
    input  logic [ADDR_W-1:0] pad_addr,
    input  logic [1:0]        tail_bytes,
    input  logic              hcopy,
    input  logic [HIDX_W-1:0] hidx,
    input  logic              urgent,
    output desc_t             desc
);
    logic [BC_W-1:0]   bc_sel;
    logic [ADDR_W-1:0] addr_sel;
    logic [MT_W-1:0]   mt_sel;

    always_comb begin
        if (use_pad) begin
            bc_sel   = pad_count(tail_bytes);
            addr_sel = pad_addr;
            mt_sel   = '0;
        end else begin
            bc_sel   = frag_len;
            addr_sel = frag_addr;
            mt_sel   = frag_mtype;
        end
        desc = make_desc(first && !use_pad, last, bc_sel, addr_sel,
                         hcopy, hidx, mt_sel, urgent);
    end

endmodule

// File: rtl/sdesc_out_slot.sv
module sdesc_out_slot #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         can_load,
    output logic         valid,
    input  logic         ready,
    output logic [W-1:0] dout
);
    assign can_load = !valid || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else begin
            if (load) begin
                valid <= 1'b1;
                dout  <= din;
            end else if (ready) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdesc_builder.sv
module sdesc_builder
    import sdesc_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int MAX_DESC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              start_urgent,
    input  logic              start_hcopy,
    input  logic [4:0]        start_hidx,
    output logic              start_rej,
    input  logic              frag_valid,
    output logic              frag_ready,
    input  logic [47:0]       frag_addr,
    input  logic [13:0]       frag_len,
    input  logic [1:0]        frag_mtype,
    input  logic [47:0]       pad_addr,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [63:0]       desc_w0,
    output logic [63:0]       desc_w1,
    output logic              frag_err
);
    localparam int DESC_W = $bits(desc_t);

    bld_state_e        state_q;
    logic              urgent_q;
    logic              hcopy_q;
    logic [HIDX_W-1:0] hidx_q;
    logic              first_q;

    logic start_fire, start_bad, frag_fire;
    logic fits, closes, need_pad;
    logic [1:0] tail_bytes;
    logic can_load, trk_load, trk_take, pad_take, slot_load, use_pad, last_now;
    desc_t built;
    logic [DESC_W-1:0] slot_q;

    assign start_ready = (state_q == ST_IDLE);
    assign start_fire  = start_valid && start_ready;
    assign start_bad   = (start_len == '0) || (start_len > LEN_W'(MAX_PKT_LEN));
    assign frag_ready  = (state_q == ST_FRAG) && can_load;
    assign frag_fire   = frag_valid && frag_ready;

    assign trk_load  = start_fire && !start_bad;
    assign trk_take  = frag_fire && fits;
    assign use_pad   = (state_q == ST_PAD);
    assign pad_take  = use_pad && can_load;
    assign slot_load = trk_take || pad_take;
    assign last_now  = use_pad || (closes && !need_pad);

    sdesc_len_track #(
        .LEN_W   (LEN_W),
        .MAX_DESC(MAX_DESC)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (trk_load),
        .load_len  (start_len),
        .take      (trk_take),
        .frag_len  (frag_len),
        .pad_take  (pad_take),
        .fits      (fits),
        .closes    (closes),
        .need_pad  (need_pad),
        .tail_bytes(tail_bytes)
    );

    sdesc_assemble u_asm (
        .use_pad   (use_pad),
        .first     (first_q),
        .last      (last_now),
        .frag_addr (frag_addr),
        .frag_len  (frag_len),
        .frag_mtype(frag_mtype),
        .pad_addr  (pad_addr),
        .tail_bytes(tail_bytes),
        .hcopy     (hcopy_q),
        .hidx      (hidx_q),
        .urgent    (urgent_q),
        .desc      (built)
    );

    sdesc_out_slot #(
        .W(DESC_W)
    ) u_slot (
        .clk     (clk),
        .rst     (rst),
        .load    (slot_load),
        .din     (built),
        .can_load(can_load),
        .valid   (desc_valid),
        .ready   (desc_ready),
        .dout    (slot_q)
    );

    assign desc_w0 = slot_q[DESC_W-1 -: 64];
    assign desc_w1 = slot_q[63:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            urgent_q  <= 1'b0;
            hcopy_q   <= 1'b0;
            hidx_q    <= '0;
            first_q   <= 1'b0;
            start_rej <= 1'b0;
            frag_err  <= 1'b0;
        end else begin
            start_rej <= start_fire && start_bad;
            unique case (state_q)
                ST_IDLE: begin
                    if (trk_load) begin
                        urgent_q <= start_urgent;
                        hcopy_q  <= start_hcopy;
                        hidx_q   <= start_hidx;
                        first_q  <= 1'b1;
                        state_q  <= ST_FRAG;
                    end
                end
                ST_FRAG: begin
                    if (frag_fire) begin
                        if (!fits) begin
                            frag_err <= 1'b1;
                        end else begin
                            first_q <= 1'b0;
                            if (closes) begin
                                state_q <= need_pad ? ST_PAD : ST_IDLE;
                            end
                        end
                    end
                end
                ST_PAD: begin
                    if (can_load) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdesc_builder_chk.sv
module sdesc_builder_chk #(
    parameter int LEN_W    = 16,
    parameter int MAX_DESC = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             start_valid,
    input logic             start_ready,
    input logic [LEN_W-1:0] start_len,
    input logic             start_rej,
    input logic             frag_ready,
    input logic             desc_valid,
    input logic             desc_ready,
    input logic [63:0]      desc_w0,
    input logic [63:0]      desc_w1,
    input logic             frag_err
);
    localparam int HC_W = $clog2(MAX_DESC + 2);

    logic [HC_W-1:0] hs_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_cnt <= '0;
        end else if (desc_valid && desc_ready) begin
            hs_cnt <= desc_w0[62] ? '0 : hs_cnt + HC_W'(1);
        end
    end

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_w0) && $stable(desc_w1));

    p_urgent_last_r8: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> (desc_w1[1] == desc_w1[0]) && (!desc_w1[1] || desc_w0[62]));

    p_reject_r2: assert property (@(posedge clk) disable iff (rst)
        start_valid && start_ready && (start_len == '0 || start_len > LEN_W'(16383))
        |=> start_rej && start_ready);

    p_idle_no_frag_r12: assert property (@(posedge clk) disable iff (rst)
        start_ready |-> !frag_ready);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        frag_err |=> frag_err);

    p_desc_limit_r10: assert property (@(posedge clk) disable iff (rst)
        desc_valid && desc_ready |-> hs_cnt < HC_W'(MAX_DESC));

    p_hdr_first_only_r5: assert property (@(posedge clk) disable iff (rst)
        desc_valid && !desc_w0[63] |-> desc_w1[15:8] == 8'd0);

endmodule

bind sdesc_builder sdesc_builder_chk #(
    .LEN_W   (LEN_W),
    .MAX_DESC(MAX_DESC)
) u_chk (.*);

// File: tb/tb_sdesc_builder.sv
module tb_sdesc_builder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [47:0] PAD_A = 48'hABCD_0000_0F00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [15:0] start_len = '0;
    logic        start_urgent = 1'b0;
    logic        start_hcopy = 1'b0;
    logic [4:0]  start_hidx = '0;
    logic        start_rej;
    logic        frag_valid = 1'b0;
    logic        frag_ready;
    logic [47:0] frag_addr = '0;
    logic [13:0] frag_len = '0;
    logic [1:0]  frag_mtype = '0;
    logic        desc_valid;
    logic        desc_ready = 1'b0;
    logic [63:0] desc_w0, desc_w1;
    logic        frag_err;

    int errors = 0;
    int checks = 0;
    int rdy_pct = 100;
    bit done = 0;
    string cur_req = "R1";

    logic [63:0] exq0[$];
    logic [63:0] exq1[$];
    logic [63:0] e0, e1, held0, held1;
    bit hold_pend = 0;

    int m_rem, m_cnt, m_plen, m_idx;
    bit m_urg, m_hc, m_first;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdesc_builder dut (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_ready(start_ready), .start_len(start_len),
        .start_urgent(start_urgent), .start_hcopy(start_hcopy), .start_hidx(start_hidx),
        .start_rej(start_rej),
        .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
        .frag_len(frag_len), .frag_mtype(frag_mtype), .pad_addr(PAD_A),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_w0(desc_w0), .desc_w1(desc_w1), .frag_err(frag_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk0(bit first, bit last, logic [13:0] bc, logic [47:0] a);
        return {first, last, bc, a};
    endfunction

    function automatic logic [63:0] mk1(bit first, bit hc, logic [4:0] idx,
                                        logic [1:0] mt, bit lu);
        return {32'd0, 16'd0, (first && hc) ? 3'd1 : 3'd0,
                (first && hc) ? idx : 5'd0, 4'd0, mt, lu, lu};
    endfunction

    // output consumer and descriptor monitor
    always @(negedge clk) begin
        if (rst) desc_ready = 1'b0;
        else     desc_ready = ($urandom_range(0, 99) < rdy_pct);
        #1;
        if (!rst) begin
            if (hold_pend) begin
                chk(desc_valid && desc_w0 == held0 && desc_w1 == held1, "R11",
                    "stalled descriptor changed", desc_w0, held0);
            end
            hold_pend = 0;
            if (desc_valid) begin
                if (desc_ready) begin
                    if (exq0.size() == 0) begin
                        chk(0, {cur_req, "/R3"}, "unexpected descriptor", desc_w0, 64'd0);
                    end else begin
                        e0 = exq0.pop_front();
                        e1 = exq1.pop_front();
                        chk(desc_w0 == e0, {cur_req, "/R3"}, "word0", desc_w0, e0);
                        chk(desc_w1 == e1, {cur_req, "/R4"}, "word1", desc_w1, e1);
                    end
                end else begin
                    hold_pend = 1;
                    held0 = desc_w0;
                    held1 = desc_w1;
                end
            end
        end else begin
            hold_pend = 0;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start_valid = 1'b0;
        frag_valid = 1'b0;
        repeat (3) @(negedge clk);
        exq0.delete();
        exq1.delete();
        rst = 1'b0;
    endtask

    task automatic start_pkt(int len, bit urg, bit hc, int idx);
        bit bad;
        bad = (len == 0) || (len > 16383);
        @(negedge clk);
        start_len = 16'(len);
        start_urgent = urg;
        start_hcopy = hc;
        start_hidx = 5'(idx);
        start_valid = 1'b1;
        #2;
        while (!start_ready) begin
            @(negedge clk);
            #2;
        end
        @(negedge clk);
        start_valid = 1'b0;
        if (bad) begin
            chk(start_rej == 1'b1, "R2", "rejection pulse", 64'(start_rej), 64'd1);
            chk(start_ready == 1'b1 && desc_valid == 1'b0, "R2", "idle after rejection",
                64'({start_ready, desc_valid}), 64'b10);
            @(negedge clk);
            chk(start_rej == 1'b0, "R2", "pulse ends", 64'(start_rej), 64'd0);
        end else begin
            chk(start_rej == 1'b0 && start_ready == 1'b0, "R12", "busy after start",
                64'({start_rej, start_ready}), 64'b00);
            m_rem = len; m_plen = len; m_cnt = 0;
            m_urg = urg; m_hc = hc; m_idx = idx; m_first = 1;
        end
    endtask

    task automatic send_frag(logic [47:0] addr, int len, logic [1:0] mt);
        bit closes, pad, drop;
        int slots;
        closes = (len == m_rem);
        pad    = closes && (m_plen % 4 != 0);
        slots  = pad ? 2 : 1;
        drop   = (len > m_rem) || (m_cnt + slots > 64);
        @(negedge clk);
        frag_addr = addr;
        frag_len = 14'(len);
        frag_mtype = mt;
        frag_valid = 1'b1;
        #2;
        while (!frag_ready) begin
            @(negedge clk);
            #2;
        end
        if (!drop) begin
            exq0.push_back(mk0(m_first, closes && !pad, 14'(len), addr));
            exq1.push_back(mk1(m_first, m_hc, 5'(m_idx), mt, closes && !pad && m_urg));
            if (pad) begin
                exq0.push_back(mk0(0, 1, 14'(4 - m_plen % 4), PAD_A));
                exq1.push_back(mk1(0, 0, 5'd0, 2'd0, m_urg));
            end
            m_first = 0;
            m_rem -= len;
            m_cnt += slots;
        end
        @(negedge clk);
        frag_valid = 1'b0;
        if (drop) begin
            chk(frag_err == 1'b1, cur_req, "dropped fragment flags error", 64'(frag_err), 64'd1);
        end
    endtask

    task automatic drain(bit need_idle);
        int n;
        n = 0;
        while ((exq0.size() != 0 || desc_valid || (need_idle && !start_ready)) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        #3;
        chk(exq0.size() == 0 && !desc_valid, cur_req, "descriptors outstanding",
            64'(exq0.size()), 64'd0);
    endtask

    task automatic rand_pkt();
        int len, rem, l;
        len = $urandom_range(1, 400);
        start_pkt(len, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 31));
        rem = len;
        while (rem > 0) begin
            l = $urandom_range(1, 64);
            if (l > rem) l = rem;
            send_frag({$urandom(), 16'($urandom())}, l, 2'($urandom_range(0, 3)));
            rem -= l;
        end
        drain(1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL %s watchdog expired act=%0d exp=0", cur_req, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));

        // R1 reset state
        repeat (2) @(negedge clk);
        #3;
        chk(!desc_valid && !frag_ready && !start_rej && !frag_err && start_ready, "R1",
            "reset outputs", 64'({desc_valid, frag_ready, start_rej, frag_err, start_ready}),
            64'b00001);
        @(negedge clk);
        rst = 1'b0;

        // R12: fragments refused while idle
        cur_req = "R12";
        @(negedge clk);
        frag_valid = 1'b1;
        frag_len = 14'd4;
        repeat (3) begin
            #2;
            chk(!frag_ready && start_ready, "R12", "idle refuses fragment",
                64'({frag_ready, start_ready}), 64'b01);
            @(negedge clk);
        end
        frag_valid = 1'b0;
        #3;
        chk(!desc_valid, "R12", "no descriptor from idle fragment", 64'(desc_valid), 64'd0);

        // R2 length rejection
        cur_req = "R2";
        start_pkt(0, 1, 1, 7);
        start_pkt(16384, 0, 0, 0);
        start_pkt(65535, 1, 0, 0);

        // R5 header copy on first only, R8 urgency on aligned close
        cur_req = "R5";
        start_pkt(8, 1, 1, 21);
        send_frag(48'h1111_2222_3330, 4, 2'd2);
        send_frag(48'h4444_5555_6660, 4, 2'd1);
        drain(1);
        cur_req = "R8";
        rdy_pct = 30;
        start_pkt(12, 1, 0, 9);
        send_frag(48'h0000_0000_1000, 3, 2'd1);
        send_frag(48'h0000_0000_2000, 4, 2'd2);
        send_frag(48'h0000_0000_3000, 5, 2'd3);
        drain(1);
        start_pkt(7, 1, 1, 2);
        send_frag(48'h0000_0000_4000, 7, 2'd2);
        drain(1);

        // R7 pad descriptor
        cur_req = "R7";
        start_pkt(5, 0, 1, 3);
        send_frag(48'h0000_0000_5000, 5, 2'd1);
        drain(1);
        start_pkt(16383, 1, 0, 0);
        send_frag(48'hFFFF_FFFF_FFF0, 16383, 2'd3);
        drain(1);
        start_pkt(6, 0, 0, 0);
        send_frag(48'h0000_0000_6000, 2, 2'd1);
        send_frag(48'h0000_0000_6100, 4, 2'd1);
        drain(1);

        // R6 random packets with random backpressure
        cur_req = "R6";
        rdy_pct = 60;
        for (int i = 0; i < 25; i++) rand_pkt();

        // R10 exactly at the limit
        cur_req = "R10";
        start_pkt(64, 1, 0, 0);
        for (int i = 0; i < 64; i++) send_frag(48'(i * 16), 1, 2'd1);
        drain(1);
        chk(frag_err == 1'b0, "R10", "64 descriptors allowed", 64'(frag_err), 64'd0);

        // R9 over-length fragment dropped, then packet completes
        cur_req = "R9";
        start_pkt(10, 0, 1, 4);
        send_frag(48'h0000_0000_7000, 12, 2'd2);
        send_frag(48'h0000_0000_7100, 10, 2'd2);
        drain(1);
        chk(frag_err == 1'b1, "R9", "error stays set", 64'(frag_err), 64'd1);

        // R10 closing fragment plus pad would exceed the limit
        do_reset();
        cur_req = "R10";
        start_pkt(66, 0, 0, 0);
        for (int i = 0; i < 63; i++) send_frag(48'(i * 8), 1, 2'd1);
        drain(0);
        send_frag(48'h0000_0000_8000, 3, 2'd1);
        repeat (4) @(negedge clk);
        #3;
        chk(!desc_valid && exq0.size() == 0 && frag_err, "R10",
            "over-limit fragment dropped", 64'({desc_valid, frag_err}), 64'b01);
        do_reset();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule